// File: doc/BRIEF.md
# Security-Gated Interrupt Pending Registers

This block is the register slice of an external interrupt and event controller serving 29 request lines. It holds two registers behind a simple word-wide bus port. The first is a software-trigger register, where software raises or drops a request on any line. The second is a pending-status register, which records requests raised either by software or by hardware edge pulses. Software clears a pending bit by writing a one to it. Every pending bit drives an interrupt request output for its line.

Each bus access carries a secure attribute and a privileged attribute. Each line has a security configuration bit and a privilege configuration bit, both supplied by separate configuration registers outside the block. The block checks both attributes bit by bit. A bit whose line rejects the access ignores the write and reads back as zero. Other bits in the same word are still served normally.

Top module: `irq_pend_gate`

## Requirements
- R1: Synchronous active-high reset clears every software-trigger bit and every pending bit, so `irq_req` is all zeros and a later read of either register returns 0; `bus_rdata` is 0 after reset.
- R2: A write at byte offset 0x10 sets each permitted software-trigger bit x to `bus_wdata[x]`: 1 activates the software request and 0 deactivates it.
- R3: A write at byte offset 0x14 clears each permitted pending bit x whose `bus_wdata[x]` is 1; bits written with 0 keep their value.
- R4: A software-trigger bit changing from 0 to 1 sets the matching pending bit at the same clock edge; writing 1 to a trigger bit that is already 1 does not set the pending bit again.
- R5: A 1 on `hw_edge[x]` for one cycle sets pending bit x at the next edge, whatever the line's security and privilege configuration.
- R6: When a set (hardware edge or trigger rise) and a permitted clear hit the same pending bit in the same cycle, the bit ends up 1.
- R7: When `line_sec_cfg[x]` is 1, an access with `bus_secure` = 0 leaves bit x of either register unchanged on a write and reads bit x as 0.
- R8: When `line_priv_cfg[x]` is 1, an access with `bus_priv` = 0 leaves bit x of either register unchanged on a write and reads bit x as 0.
- R9: When both configuration bits of line x are 0, secure and non-secure, privileged and unprivileged accesses all reach bit x.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd` is high and is 0 in any cycle after one with no read; offsets other than 0x10 and 0x14 read 0 and ignore writes.
- R11: Bits 31:29 of `bus_rdata` are always 0.
- R12: `irq_req[x]` is 1 exactly while pending bit x is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per word write |
| bus_rd | input | 1 | Read strobe; data is returned next cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access carries the secure attribute |
| bus_priv | input | 1 | Access carries the privileged attribute |
| line_sec_cfg | input | 29 | Per-line security configuration; 1 means the line admits only secure accesses |
| line_priv_cfg | input | 29 | Per-line privilege configuration; 1 means the line admits only privileged accesses |
| hw_edge | input | 29 | One-cycle hardware edge pulses that set pending bits |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 29 | Per-line interrupt request |

## Verification
A corrupted pending bit is visible at once on `irq_req`, one edge after the event that caused it. This means the bench can catch a bad set, clear or set-over-clear priority without issuing any read. A corrupted trigger bit stays hidden until it is read back, or until its next rising write fails to raise the pending bit as expected. For that reason, the vector table reads the trigger register again after every write pattern that could change it. A bit filtered with the wrong mask shows up in the next cycle's read data, either as a one that should read as zero or as a written value that did not stick.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int unsigned LINES  = 29;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] TRIG_OFS = 8'h10;
    localparam logic [ADDR_W-1:0] PEND_OFS = 8'h14;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TRIG = 2'd1,
        SEL_PEND = 2'd2
    } reg_sel_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              secure;
        logic              priv;
    } bus_req_t;

    function automatic reg_sel_t decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        if (a == TRIG_OFS)      s = SEL_TRIG;
        else if (a == PEND_OFS) s = SEL_PEND;
        else                    s = SEL_NONE;
        return s;
    endfunction

    function automatic logic line_ok(input logic sec_cfg, input logic priv_cfg,
                                     input logic secure, input logic priv);
        return (!sec_cfg || secure) && (!priv_cfg || priv);
    endfunction

endpackage

// File: rtl/irqp_filter.sv
module irqp_filter #(
    parameter int unsigned N = irqp_pkg::LINES
) (
    input  logic [N-1:0] sec_cfg,
    input  logic [N-1:0] priv_cfg,
    input  logic         secure,
    input  logic         priv,
    output logic [N-1:0] grant
);
    import irqp_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign grant[i] = line_ok(sec_cfg[i], priv_cfg[i], secure, priv);
    end

endmodule

// File: rtl/irqp_trig_reg.sv
module irqp_trig_reg #(
    parameter int unsigned N = irqp_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] grant,
    output logic [N-1:0] trig_q,
    output logic [N-1:0] rise
);
    logic [N-1:0] trig_d;

    always_comb begin
        trig_d = trig_q;
        if (wr_en) trig_d = (trig_q & ~grant) | (wdata & grant);
    end

    assign rise = trig_d & ~trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= '0;
        else     trig_q <= trig_d;
    end

    // R7 R8: bits refused by the filter keep their value across a write
    blocked_trig_stable_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((trig_q ^ $past(trig_q)) & ~$past(grant)) == '0));

    // R2: without a write the trigger register holds
    trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (trig_q == $past(trig_q)));

endmodule

// File: rtl/irqp_pend_reg.sv
module irqp_pend_reg #(
    parameter int unsigned N = irqp_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] grant,
    input  logic [N-1:0] set_vec,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] clr_vec;
    logic [N-1:0] pend_d;

    assign clr_vec = clr_en ? (wdata & grant) : '0;

    always_comb begin
        pend_d = pend_q;
        for (int i = 0; i < N; i++) begin
            if (set_vec[i])      pend_d[i] = 1'b1;
            else if (clr_vec[i]) pend_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // R5 R6: any set request is visible as a pending bit next cycle
    set_reaches_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R3: a pending bit only drops when a permitted clear hit it
    no_spurious_drop_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

    // R3: a permitted clear with no competing set empties the bit
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> ((pend_q & $past(clr_vec) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/irqp_read_mux.sv
module irqp_read_mux #(
    parameter int unsigned N      = irqp_pkg::LINES,
    parameter int unsigned DATA_W = irqp_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  irqp_pkg::reg_sel_t sel,
    input  logic [N-1:0]      trig,
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      grant,
    output logic [DATA_W-1:0] rdata_q
);
    import irqp_pkg::*;

    logic [N-1:0] picked;

    always_comb begin
        unique case (sel)
            SEL_TRIG: picked = trig;
            SEL_PEND: picked = pend;
            default:  picked = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= DATA_W'(picked & grant);
        else            rdata_q <= '0;
    end

    // R11: bits above the last line never carry data
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_q[DATA_W-1:N] == '0);

    // R10: no read strobe means zero data next cycle
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata_q == '0));

    // R7 R8: refused lines read as zero
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ((rdata_q[N-1:0] & ~$past(grant)) == '0));

endmodule

// File: rtl/irq_pend_gate.sv
module irq_pend_gate #(
    parameter int unsigned NUM_LINES = irqp_pkg::LINES,
    parameter int unsigned DATA_W    = irqp_pkg::DATA_W,
    parameter int unsigned ADDR_W    = irqp_pkg::ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_secure,
    input  logic                 bus_priv,
    input  logic [NUM_LINES-1:0] line_sec_cfg,
    input  logic [NUM_LINES-1:0] line_priv_cfg,
    input  logic [NUM_LINES-1:0] hw_edge,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_req
);
    import irqp_pkg::*;

    bus_req_t             req;
    reg_sel_t             sel;
    logic [NUM_LINES-1:0] grant;
    logic [NUM_LINES-1:0] trig_q;
    logic [NUM_LINES-1:0] trig_rise;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] wdata_lines;
    logic                 unused_wdata_hi;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata,
                   secure: bus_secure, priv: bus_priv};
    assign sel             = decode_sel(req.addr);
    assign wdata_lines     = req.wdata[NUM_LINES-1:0];
    assign unused_wdata_hi = ^req.wdata[DATA_W-1:NUM_LINES];

    irqp_filter #(.N(NUM_LINES)) u_filter (
        .sec_cfg  (line_sec_cfg),
        .priv_cfg (line_priv_cfg),
        .secure   (req.secure),
        .priv     (req.priv),
        .grant    (grant)
    );

    irqp_trig_reg #(.N(NUM_LINES)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req.wr && sel == SEL_TRIG),
        .wdata  (wdata_lines),
        .grant  (grant),
        .trig_q (trig_q),
        .rise   (trig_rise)
    );

    assign set_vec = hw_edge | trig_rise;

    irqp_pend_reg #(.N(NUM_LINES)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (req.wr && sel == SEL_PEND),
        .wdata   (wdata_lines),
        .grant   (grant),
        .set_vec (set_vec),
        .pend_q  (pend_q)
    );

    irqp_read_mux #(.N(NUM_LINES), .DATA_W(DATA_W)) u_rmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (req.rd),
        .sel     (sel),
        .trig    (trig_q),
        .pend    (pend_q),
        .grant   (grant),
        .rdata_q (bus_rdata)
    );

    assign irq_req = pend_q;

    // R4: a trigger bit that became 1 leaves its pending bit set
    trig_rise_pends_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((trig_q & ~$past(trig_q) & ~irq_req) == '0));

    // R10: a write to an unmapped offset leaves the interrupt lines alone
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE && hw_edge == '0) |=> (irq_req == $past(irq_req)));

    // R1: the cycle after reset everything is empty
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_req == '0 && bus_rdata == '0));

endmodule

// File: tb/irq_pend_gate_tb.sv
module irq_pend_gate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_secure = 1'b0;
    logic        bus_priv = 1'b0;
    logic [28:0] line_sec_cfg = 29'h0000_00F0;
    logic [28:0] line_priv_cfg = 29'h0000_0F00;
    logic [28:0] hw_edge = '0;
    logic [31:0] bus_rdata;
    logic [28:0] irq_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_pend_gate u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_priv(bus_priv), .line_sec_cfg(line_sec_cfg),
        .line_priv_cfg(line_priv_cfg), .hw_edge(hw_edge),
        .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        sec;
        logic        prv;
        logic [28:0] hw;
        logic [31:0] exp_rd;
        logic [28:0] exp_irq;
        logic [3:0]  req;
    } vec_t;

    // Secured lines 4..7, privileged lines 8..11 during the table.
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R2 R4: open write of all ones sets trigger and pending
        '{1'b1,1'b0,8'h10,32'h1FFF_FFFF,1'b1,1'b1,29'h0,32'h0,29'h1FFF_FFFF,4'd4},
        // R7: non-secure read masks lines 4..7
        '{1'b0,1'b1,8'h10,32'h0,1'b0,1'b1,29'h0,32'h1FFF_FF0F,29'h1FFF_FFFF,4'd7},
        // R8: unprivileged read masks lines 8..11
        '{1'b0,1'b1,8'h10,32'h0,1'b1,1'b0,29'h0,32'h1FFF_F0FF,29'h1FFF_FFFF,4'd8},
        // R3 R7 R8: restricted clear leaves lines 4..11 pending
        '{1'b1,1'b0,8'h14,32'hFFFF_FFFF,1'b0,1'b0,29'h0,32'h0,29'h0000_0FF0,4'd3},
        // R9: full access read of pending
        '{1'b0,1'b1,8'h14,32'h0,1'b1,1'b1,29'h0,32'h0000_0FF0,29'h0000_0FF0,4'd9},
        // R3: writing zeros clears nothing
        '{1'b1,1'b0,8'h14,32'h0,1'b1,1'b1,29'h0,32'h0,29'h0000_0FF0,4'd3},
        // R9: full access clear
        '{1'b1,1'b0,8'h14,32'hFFFF_FFFF,1'b1,1'b1,29'h0,32'h0,29'h0,4'd9},
        // R4: rewriting ones to set triggers does not pend again
        '{1'b1,1'b0,8'h10,32'h1FFF_FFFF,1'b1,1'b1,29'h0,32'h0,29'h0,4'd4},
        // R2: restricted write of zeros drops only open lines
        '{1'b1,1'b0,8'h10,32'h0,1'b0,1'b0,29'h0,32'h0,29'h0,4'd2},
        // R2: trigger read back
        '{1'b0,1'b1,8'h10,32'h0,1'b1,1'b1,29'h0,32'h0000_0FF0,29'h0,4'd2},
        // R4: restricted write of ones raises only the dropped lines
        '{1'b1,1'b0,8'h10,32'h1FFF_FFFF,1'b0,1'b0,29'h0,32'h0,29'h1FFF_F00F,4'd4},
        // R10: unmapped offset reads zero
        '{1'b0,1'b1,8'h18,32'h0,1'b1,1'b1,29'h0,32'h0,29'h1FFF_F00F,4'd10},
        // R10: unmapped offset write ignored
        '{1'b1,1'b0,8'h18,32'hFFFF_FFFF,1'b1,1'b1,29'h0,32'h0,29'h1FFF_F00F,4'd10},
        // R6: edge and clear on line 0 together, set wins
        '{1'b1,1'b0,8'h14,32'h0000_0001,1'b1,1'b1,29'h1,32'h0,29'h1FFF_F00F,4'd6},
        // R5: edges on secured lines 4,5 still pend
        '{1'b0,1'b0,8'h00,32'h0,1'b0,1'b0,29'h30,32'h0,29'h1FFF_F03F,4'd5},
        // R11 R12: full read of pending, top bits zero
        '{1'b0,1'b1,8'h14,32'h0,1'b1,1'b1,29'h0,32'h1FFF_F03F,29'h1FFF_F03F,4'd11},
        // R10: idle cycle returns zero data
        '{1'b0,1'b0,8'h14,32'h0,1'b1,1'b1,29'h0,32'h0,29'h1FFF_F03F,4'd10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic [7:0] a,
                         input logic [31:0] d, input logic s, input logic p,
                         input logic [28:0] hw);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        bus_secure = s; bus_priv = p; hw_edge = hw;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; hw_edge = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        check("R1 irq after reset", {3'b0, irq_req}, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        drive(1'b0, 1'b1, 8'h14, 32'h0, 1'b1, 1'b1, 29'h0);
        check("R1 pending reads zero", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wdata,
                  VECS[i].sec, VECS[i].prv, VECS[i].hw);
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
            // R12: irq follows pending state
            check($sformatf("R12 vec%0d irq", i), {3'b0, irq_req}, {3'b0, VECS[i].exp_irq});
        end

        // R11: all ones written, top bits still read zero
        drive(1'b0, 1'b1, 8'h10, 32'h0, 1'b1, 1'b1, 29'h0);
        check("R11 trigger read top bits", bus_rdata, 32'h1FFF_FFFF);

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after mid reset", {3'b0, irq_req}, 32'h0);
        drive(1'b0, 1'b1, 8'h10, 32'h0, 1'b1, 1'b1, 29'h0);
        check("R1 trigger after mid reset", bus_rdata, 32'h0);

        // R7: secure-only line 20, non-secure write dropped
        line_sec_cfg = 29'h0010_0000;
        line_priv_cfg = 29'h0;
        drive(1'b1, 1'b0, 8'h10, 32'h0010_0000, 1'b0, 1'b1, 29'h0);
        check("R7 dropped trigger write", {3'b0, irq_req}, 32'h0);
        drive(1'b1, 1'b0, 8'h10, 32'h0010_0000, 1'b1, 1'b0, 29'h0);
        check("R7 secure trigger write pends", {3'b0, irq_req}, 32'h0010_0000);
        // R8: privileged-only line 20 now, unprivileged clear dropped
        line_sec_cfg = 29'h0;
        line_priv_cfg = 29'h0010_0000;
        drive(1'b1, 1'b0, 8'h14, 32'hFFFF_FFFF, 1'b1, 1'b0, 29'h0);
        check("R8 dropped clear", {3'b0, irq_req}, 32'h0010_0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule